// File: doc/BRIEF.md
# Display Control and Status Register Bank

This block is the upper half of a 32-byte, byte-wide register window for a frame buffer. It holds a control byte whose top bit arms a frame-end interrupt, a status byte that carries a sticky interrupt-pending flag, and a run of plain storage bytes. Software uses these storage bytes for cursor position and video timing values. The display path delivers a one-cycle frame-end pulse. When the interrupt is armed, that pulse latches the pending flag, and the flag drives a level interrupt line until software acknowledges it.

The lower half of the window is not decoded here. Reads of that half return zero, and writes to it are dropped. Reads are combinational from the address. A write takes effect at the clock edge where the write strobe is high. The status byte reports the pending flag together with fixed identity bits, which tell software the monitor type and that the board is a colour board.

Top module: `dcr_top`

## Requirements
- R1: After reset the interrupt output is low, the control byte (offset 0x10) reads 0x00, the status byte (offset 0x11) reads 0x61, and every storage byte at 0x12 to 0x1F reads 0x00.
- R2: Offset 0x10 is the control byte. A write stores all 8 bits, and a read returns them.
- R3: A frame-end pulse sampled while control bit 7 is 1 sets the pending flag. From the next cycle the interrupt output is high and the status byte reads 0xE1.
- R4: A frame-end pulse sampled while control bit 7 is 0 does not set the pending flag and does not raise the interrupt.
- R5: A write of any data to offset 0x11 while the flag is pending clears it. From the next cycle the interrupt output is low and the status byte reads 0x61.
- R6: A write to offset 0x11 while nothing is pending changes nothing, and its data is never stored.
- R7: Once set, the pending flag stays set until it is acknowledged, even if control bit 7 is cleared or further frame-end pulses arrive.
- R8: If a frame-end pulse (with control bit 7 at 1) and a status write fall in the same cycle, the pending flag ends up set.
- R9: Offsets 0x12 to 0x1F are independent read/write bytes, stored at index (offset minus 0x10).
- R10: Offsets 0x00 to 0x0F read as 0x00. Writes to them change no register.
- R11: The status byte always reads as 0x61 with bit 7 equal to the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset within the 32-byte window |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| frame_end | input | 1 | One-cycle end-of-frame pulse from the display path |
| irq | output | 1 | Level interrupt, high while the flag is pending |

## Verification
The assertions assume that frame_end and the bus inputs are synchronous to clk and stable around the rising edge. They also assume that a status write can be told apart from a frame-end in the same cycle only by the priority rule, so the clear check only applies when no frame-end is present. The stimulus changes every input on the falling edge and holds it for one full cycle. Frame-end is asserted for exactly one cycle, except in the race scenario, where it is deliberately placed on the same edge as a status write.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    // register indices inside the decoded upper half of the window
    localparam int unsigned CTRL_IDX = 0;
    localparam int unsigned STAT_IDX = 1;
    localparam int unsigned GEN_LO   = 2;
endpackage

// File: rtl/dcr_decode.sv
module dcr_decode #(
    parameter int unsigned ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    output logic                          in_win,
    output logic [ADDR_W-2:0]             idx,
    output logic [(1<<(ADDR_W-1))-1:0]    wr_hit
);
    localparam int unsigned IDX_W = ADDR_W - 1;
    localparam int unsigned NREG  = 1 << IDX_W;

    always_comb begin
        in_win = bus_addr[ADDR_W-1];
        idx    = bus_addr[IDX_W-1:0];
        wr_hit = '0;
        for (int i = 0; i < NREG; i++) begin
            if (bus_wr && in_win && (idx == IDX_W'(i))) begin
                wr_hit[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dcr_store.sv
module dcr_store #(
    parameter int unsigned NREG   = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NREG-1:0]                   wr_hit,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [NREG-1:0][DATA_W-1:0]       regs_q
);
    import dcr_pkg::*;

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (i == STAT_IDX) begin
                st_d.regs[i] = '0;
            end else if (wr_hit[i]) begin
                st_d.regs[i] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs_q = st_q.regs;
endmodule

// File: rtl/dcr_pend.sv
module dcr_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic arm,
    input  logic ack,
    output logic pend_q
);
    typedef struct packed {
        logic pend;
    } pend_t;

    pend_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (ack && p_q.pend) p_d.pend = 1'b0;
        // a new event outranks an acknowledge in the same cycle
        if (frame_end && arm) p_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign pend_q = p_q.pend;
endmodule

// File: rtl/dcr_rdmux.sv
module dcr_rdmux #(
    parameter int unsigned IDX_W   = 4,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned IRQ_BIT = 7,
    parameter logic [7:0]  ID_BITS = 8'h61
) (
    input  logic                                 in_win,
    input  logic [IDX_W-1:0]                     idx,
    input  logic [(1<<IDX_W)-1:0][DATA_W-1:0]    regs_q,
    input  logic                                 pend,
    output logic [DATA_W-1:0]                    rdata
);
    import dcr_pkg::*;

    always_comb begin
        rdata = '0;
        if (in_win) begin
            if (idx == IDX_W'(STAT_IDX)) begin
                rdata = DATA_W'(ID_BITS);
                rdata[IRQ_BIT] = pend;
            end else begin
                rdata = regs_q[idx];
            end
        end
    end
endmodule

// File: rtl/dcr_top.sv
module dcr_top #(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned IRQ_BIT = 7,
    parameter logic [7:0]  ID_BITS = 8'h61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              frame_end,
    output logic              irq
);
    import dcr_pkg::*;

    localparam int unsigned IDX_W = ADDR_W - 1;
    localparam int unsigned NREG  = 1 << IDX_W;

    logic                         in_win;
    logic [IDX_W-1:0]             idx;
    logic [NREG-1:0]              wr_hit;
    logic [NREG-1:0][DATA_W-1:0]  regs_q;
    logic [DATA_W-1:0]            ctrl_q;
    logic                         pend_q;

    dcr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .in_win   (in_win),
        .idx      (idx),
        .wr_hit   (wr_hit)
    );

    dcr_store #(.NREG(NREG), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .bus_wdata (bus_wdata),
        .regs_q    (regs_q)
    );

    assign ctrl_q = regs_q[CTRL_IDX];

    dcr_pend u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .arm       (ctrl_q[IRQ_BIT]),
        .ack       (wr_hit[STAT_IDX]),
        .pend_q    (pend_q)
    );

    dcr_rdmux #(.IDX_W(IDX_W), .DATA_W(DATA_W), .IRQ_BIT(IRQ_BIT), .ID_BITS(ID_BITS)) u_rd (
        .in_win (in_win),
        .idx    (idx),
        .regs_q (regs_q),
        .pend   (pend_q),
        .rdata  (bus_rdata)
    );

    assign irq = pend_q;
endmodule

// File: rtl/dcr_chk.sv
module dcr_chk #(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned IRQ_BIT = 7,
    parameter logic [7:0]  ID_BITS = 8'h61
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              frame_end,
    input logic              arm,
    input logic              irq
);
    localparam int unsigned NREG = 1 << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NREG + 1);

    logic stat_wr;
    assign stat_wr = bus_wr && (bus_addr == STAT_A);

    // R1
    reset_irq_low_chk: assert property (@(posedge clk) !rst_n |=> !irq);

    // R3
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end && arm |=> irq);

    // R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && !(frame_end && arm) |=> !irq);

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && stat_wr && !frame_end |=> !irq);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !stat_wr |=> irq);

    // R8
    race_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && frame_end && arm |=> irq);

    // R11
    status_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == STAT_A |-> bus_rdata == (DATA_W'(ID_BITS) | (DATA_W'(irq) << IRQ_BIT)));

    // R10
    low_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr[ADDR_W-1] |-> bus_rdata == '0);
endmodule

bind dcr_top dcr_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_BIT(IRQ_BIT), .ID_BITS(ID_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .frame_end (frame_end),
    .arm       (ctrl_q[IRQ_BIT]),
    .irq       (irq)
);

// File: tb/sim_dcr_top.sv
module sim_dcr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       frame_end = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    dcr_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_end(frame_end), .irq(irq)
    );

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk8(req, bus_rdata, exp);
    endtask

    task automatic chk_irq(input string req, input logic exp);
        chk8(req, {7'b0, irq}, {7'b0, exp});
    endtask

    // all drive changes happen at the falling edge
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic frame();
        frame_end = 1'b1;
        @(posedge clk); @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic frame_and_ack(input logic [7:0] d);
        frame_end = 1'b1; bus_addr = 5'h11; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        frame_end = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk_irq("R1 irq", 1'b0);
        rd("R1 ctrl", 5'h10, 8'h00);
        rd("R1 status", 5'h11, 8'h61);
        for (int a = 'h12; a < 'h20; a++) rd("R1 storage", 5'(a), 8'h00);
    endtask

    task automatic t_ctrl();
        wr(5'h10, 8'hA5); rd("R2 ctrl A5", 5'h10, 8'hA5);
        wr(5'h10, 8'h5A); rd("R2 ctrl 5A", 5'h10, 8'h5A);
        wr(5'h10, 8'h00); rd("R2 ctrl 00", 5'h10, 8'h00);
    endtask

    task automatic t_gen();
        for (int a = 'h12; a < 'h20; a++) wr(5'(a), 8'(a * 7 + 3));
        for (int a = 'h12; a < 'h20; a++) rd("R9 storage", 5'(a), 8'(a * 7 + 3));
        wr(5'h1F, 8'hFF);
        rd("R9 neighbour", 5'h1E, 8'('h1E * 7 + 3));
        rd("R9 last", 5'h1F, 8'hFF);
        rd("R9 ctrl untouched", 5'h10, 8'h00);
    endtask

    task automatic t_undec();
        for (int a = 0; a < 'h10; a++) wr(5'(a), 8'hFF);
        for (int a = 0; a < 'h10; a++) rd("R10 low half", 5'(a), 8'h00);
        rd("R10 ctrl kept", 5'h10, 8'h00);
        rd("R10 status kept", 5'h11, 8'h61);
        rd("R10 storage kept", 5'h12, 8'('h12 * 7 + 3));
        chk_irq("R10 irq", 1'b0);
    endtask

    task automatic t_noarm();
        wr(5'h10, 8'h7F);
        frame();
        chk_irq("R4 irq", 1'b0);
        rd("R4 status", 5'h11, 8'h61);
    endtask

    task automatic t_arm();
        wr(5'h10, 8'h80);
        frame();
        chk_irq("R3 irq", 1'b1);
        rd("R3 R11 status", 5'h11, 8'hE1);
        wr(5'h10, 8'h00);
        chk_irq("R7 disarmed", 1'b1);
        frame(); frame();
        chk_irq("R7 more frames", 1'b1);
        rd("R7 status", 5'h11, 8'hE1);
    endtask

    task automatic t_ack();
        wr(5'h11, 8'h00);
        chk_irq("R5 irq", 1'b0);
        rd("R5 R11 status", 5'h11, 8'h61);
        wr(5'h11, 8'hFF);
        chk_irq("R6 irq", 1'b0);
        rd("R6 status", 5'h11, 8'h61);
        rd("R6 ctrl", 5'h10, 8'h00);
    endtask

    task automatic t_race();
        wr(5'h10, 8'h80);
        frame_and_ack(8'h80);
        chk_irq("R8 from idle", 1'b1);
        frame_and_ack(8'h00);
        chk_irq("R8 while pending", 1'b1);
        rd("R8 status", 5'h11, 8'hE1);
        wr(5'h11, 8'h12);
        chk_irq("R5 final ack", 1'b0);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_gen();
        t_undec();
        t_noarm();
        t_arm();
        t_ack();
        t_race();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule